// File: doc/BRIEF.md
# Three-Line Synchronous Serial Slave Port

This block is the slave side of a three-line serial port. A master controls an access strobe, a serial clock and one bidirectional data line. Here the data line is split into a data input, a data output and an output enable. The slave samples the access strobe, the serial clock and the incoming data in the system clock domain. It finds the serial clock edges there, then moves bytes between the serial line and a byte-wide register file.

An access opens when the strobe rises. The first eight serial bits form a command. Bit 0 of the command selects the direction. Bits 7:1 give the starting byte address. A write access then takes whole data bytes and stores each one at the current address. A read access sends bytes from the register file. In both cases the address steps up by one after every byte. Dropping the strobe ends the access at once, whatever its progress. Every byte on the line, command or data, travels least significant bit first.

The register-file side has four signals: an address, a write strobe of one cycle, the write data, and a read-data input. The read-data input is expected to follow the address without delay.

Top module: `tws_serial_slave`

## Requirements
- R1: While the system reset is asserted, dq_oe and rf_we are 0.
- R2: The command is shifted in on rising serial clock edges, LSB first. Command bit 0 = 1 selects read and 0 selects write. Command bits 7:1 are the starting byte address.
- R3: In a write access, each group of 8 bits taken on rising edges forms a byte, LSB first. The byte is written to the current address with a single-cycle rf_we pulse, and the address then increases by one.
- R4: In a read access, the byte at the current address is sent LSB first. Each bit is placed on dq_o after a falling serial clock edge. The first bit follows the falling edge after the eighth command bit. The address increases by one after each byte.
- R5: dq_oe is 0 whenever the synchronised serial clock is high.
- R6: When the access strobe goes low, dq_oe falls within two system clocks of the change. The slave is then idle until the strobe rises again.
- R7: A write byte cut short by the strobe going low is discarded, and no rf_we pulse is issued for it.
- R8: The byte address is 7 bits wide and wraps from 127 to 0.
- R9: rf_we is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| ser_rst_i | input | 1 | Access strobe from the master, active high |
| ser_clk_i | input | 1 | Serial clock from the master |
| dq_i | input | 1 | Serial data in |
| dq_o | output | 1 | Serial data out |
| dq_oe | output | 1 | Drive enable for the serial data line |
| rf_addr | output | 7 | Register-file byte address |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_rdata | input | 8 | Register-file read data for rf_addr |

## Verification
The assertions check four things on every cycle. The line is never driven while the serial clock, as seen after synchronisation, is high. Drive stops within the synchroniser delay once the strobe falls. A write strobe lasts exactly one cycle, only inside an open access, and is followed by an address one higher. Other behaviour only the bench scenarios can show: LSB-first assembly of commands and bytes, the byte values read back, the address wrap at the top of the map, and the discard of a cut-short write byte. Each of these needs a whole serial transaction before it is visible.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
// Multi-bit bank of independent flop-chain synchronisers.
module tws_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tws_ctrl.sv
// Access sequencer: command capture, write assembly, read serialisation.
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_lvl,
  input  logic              clk_lvl,
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              dq_lvl,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              dq_o,
  output logic              dq_oe,
  output logic [CMD_W-2:0]  rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we
);
  localparam int ADDR_W = CMD_W - 1;
  localparam int SH_W   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W  = $clog2(SH_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  tws_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d, waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d;
  logic              dq_q, dq_d;
  logic              drv_q, drv_d;

  logic [CMD_W-1:0]  cmd_word;
  logic [DATA_W-1:0] data_word;
  logic [DATA_W-1:0] tx_src;

  assign cmd_word  = {dq_lvl, sh_q[CMD_W-1:1]};
  assign data_word = {dq_lvl, sh_q[DATA_W-1:1]};
  assign tx_src    = (cnt_q == '0) ? rf_rdata : sh_q[DATA_W-1:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    dq_d    = dq_q;
    drv_d   = drv_q;
    if (!rst_lvl) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_CMD;
          cnt_d   = '0;
        end
        ST_CMD: if (clk_rise) begin
          sh_d[CMD_W-1:0] = cmd_word;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CMD_LAST) begin
            cnt_d   = '0;
            addr_d  = cmd_word[CMD_W-1:1];
            state_d = cmd_word[0] ? ST_RD : ST_WR;
          end
        end
        ST_WR: if (clk_rise) begin
          sh_d[DATA_W-1:0] = data_word;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == DATA_LAST) begin
            cnt_d   = '0;
            we_d    = 1'b1;
            wdata_d = data_word;
            waddr_d = addr_q;
            addr_d  = addr_q + 1'b1;
          end
        end
        ST_RD: if (clk_fall) begin
          dq_d  = tx_src[0];
          sh_d[DATA_W-1:0] = tx_src >> 1;
          drv_d = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == DATA_LAST) begin
            cnt_d  = '0;
            addr_d = addr_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      dq_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      dq_q    <= dq_d;
      drv_q   <= drv_d;
    end
  end

  assign dq_o     = dq_q;
  assign dq_oe    = (state_q == ST_RD) && drv_q && !clk_lvl && rst_lvl;
  assign rf_addr  = we_q ? waddr_q : addr_q;
  assign rf_wdata = wdata_q;
  assign rf_we    = we_q;
endmodule

// File: rtl/tws_serial_slave.sv
module tws_serial_slave #(
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = CMD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_rst_i,
  input  logic              ser_clk_i,
  input  logic              dq_i,
  output logic              dq_o,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  input  logic [DATA_W-1:0] rf_rdata
);
  logic [2:0] raw_in, synced;
  logic       rst_sync, clk_sync, dq_sync;
  logic       clk_prev_q;
  logic       clk_rise, clk_fall;

  assign raw_in = {dq_i, ser_clk_i, ser_rst_i};

  tws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (synced)
  );

  assign rst_sync = synced[0];
  assign clk_sync = synced[1];
  assign dq_sync  = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b0;
    else        clk_prev_q <= clk_sync;
  end

  assign clk_rise = clk_sync && !clk_prev_q;
  assign clk_fall = !clk_sync && clk_prev_q;

  tws_ctrl #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_lvl  (rst_sync),
    .clk_lvl  (clk_sync),
    .clk_rise (clk_rise),
    .clk_fall (clk_fall),
    .dq_lvl   (dq_sync),
    .rf_rdata (rf_rdata),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_we    (rf_we)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_rst_i,
  input logic              ser_clk_i,
  input logic              dq_oe,
  input logic              rf_we,
  input logic [ADDR_W-1:0] rf_addr
);
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!dq_oe && !rf_we);
    end
  end

  // R5: synchronised clock is the raw clock two system edges earlier
  a_r5_float_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(ser_clk_i, 2));

  a_r6_release_on_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ser_rst_i, 2) |-> !dq_oe);

  a_r9_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  a_r7_we_inside_access: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(ser_rst_i, 3));

  a_r3_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> rf_addr == ADDR_W'($past(rf_addr) + 1'b1));
endmodule

bind tws_serial_slave tws_checker #(.ADDR_W(ADDR_W)) u_tws_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_rst_i (ser_rst_i),
  .ser_clk_i (ser_clk_i),
  .dq_oe     (dq_oe),
  .rf_we     (rf_we),
  .rf_addr   (rf_addr)
);

// File: tb/tb_tws_serial_slave.sv
`timescale 1ns/1ps
module tb_tws_serial_slave;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_rst_i = 1'b0;
  logic       ser_clk_i = 1'b0;
  logic       dq_i = 1'b0;
  logic       dq_o, dq_oe, rf_we;
  logic [6:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] mem [128];

  int checks = 0;
  int failures = 0;
  logic [14:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .ser_rst_i(ser_rst_i), .ser_clk_i(ser_clk_i),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata)
  );

  // Register-file model owned by the bench
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
    end
  end
  assign rf_rdata = mem[rf_addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pop and compare each write strobe (R3, R7, R8)
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected write", {17'd0, rf_addr, rf_wdata}, 32'hFFFF);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        check("R3 write addr/data", {17'd0, rf_addr, rf_wdata}, {17'd0, e});
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_clk_i = 1'b0; dq_i = b;
    wait_n(HALF);
    ser_clk_i = 1'b1;
    wait_n(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      ser_clk_i = 1'b0;
      wait_n(HALF);
      check("R4 oe during low phase", {31'd0, dq_oe}, 32'd1);
      v[i] = dq_o;
      ser_clk_i = 1'b1;
      wait_n(HALF - 2);
      check("R5 float while clock high", {31'd0, dq_oe}, 32'd0);
      wait_n(2);
    end
  endtask

  task automatic open_access();
    ser_clk_i = 1'b0;
    ser_rst_i = 1'b1;
    wait_n(HALF);
  endtask

  task automatic close_access();
    ser_clk_i = 1'b0;
    wait_n(HALF);
    ser_rst_i = 1'b0;
    wait_n(2 * HALF);
  endtask

  // Driver: write bytes and push expected writes (R2, R3, R8)
  task automatic do_write(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1);
    open_access();
    send_byte({a, 1'b0});
    exp_q.push_back({a, d0});
    send_byte(d0);
    exp_q.push_back({7'(a + 1), d1});
    send_byte(d1);
    close_access();
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string req);
    logic [7:0] got;
    open_access();
    send_byte({a, 1'b1});
    for (int k = 0; k < n; k++) begin
      logic [7:0] exp;
      exp = mem[7'(a + k)];
      recv_byte(got);
      check(req, {24'd0, got}, {24'd0, exp});
    end
    close_access();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] got;
    wait_n(3);
    check("R1 reset oe", {31'd0, dq_oe}, 32'd0);
    check("R1 reset we", {31'd0, rf_we}, 32'd0);
    rst_n = 1'b1;
    wait_n(4);

    // R2 R3: write two bytes at 5
    do_write(7'd5, 8'hA5, 8'h3C);
    check("R3 queue drained", exp_q.size(), 0);
    check("R3 mem[5]", {24'd0, mem[5]}, 32'hA5);
    check("R3 mem[6]", {24'd0, mem[6]}, 32'h3C);

    // R4: read back, plus an untouched neighbour
    do_read(7'd5, 3, "R4 read byte");

    // R8: wrap from 127 to 0
    do_write(7'd127, 8'h11, 8'h22);
    check("R8 mem[127]", {24'd0, mem[127]}, 32'h11);
    check("R8 mem[0] after wrap", {24'd0, mem[0]}, 32'h22);
    do_read(7'd127, 2, "R8 read across wrap");

    // R7: partial byte cut by strobe; no write may appear
    open_access();
    send_byte({7'd10, 1'b0});
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    close_access();
    check("R7 mem[10] kept", {24'd0, mem[10]}, {24'd0, 8'(10 * 7 + 3)});
    do_read(7'd10, 1, "R7 read after discard");

    // R6: strobe drop during a driven low phase
    open_access();
    send_byte({7'd20, 1'b1});
    ser_clk_i = 1'b0;
    wait_n(HALF);
    check("R6 oe before drop", {31'd0, dq_oe}, 32'd1);
    ser_rst_i = 1'b0;
    wait_n(3);
    check("R6 oe after drop", {31'd0, dq_oe}, 32'd0);
    wait_n(2 * HALF);
    check("R6 stays idle", {31'd0, dq_oe}, 32'd0);

    // R6: new access after abort starts with a fresh command
    do_read(7'd20, 1, "R6 read after abort");

    // R2: another address with mixed bits, LSB-first order
    do_write(7'h55, 8'h81, 8'h7E);
    recv_check_done: begin
      do_read(7'h55, 2, "R2 command/address decode");
    end
    check("R9 no pending writes", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule